// File: doc/BRIEF.md
# Password-Gated Configuration Write Lock

This block sits in front of a bank of 32-bit configuration registers and decides which bus writes may reach them. Word offset 0 is a write-access control register that holds a single lock bit. Every other offset maps to a protected register. A write to a protected register is forwarded only while the bank is unlocked. The bank is forwarded as a one-cycle write strobe for that register, together with a registered copy of the write data.

Software unlocks the bank by writing a word to offset 0 whose upper 24 bits carry a fixed password. It then performs its updates and relocks the bank with the same password and bit 0 cleared. A word with the wrong password at offset 0 changes nothing. Reads never depend on the lock. Offset 0 reads back the lock bit. A protected offset reads back the contents that the bank presents on its read-back input.

Top module: `regbank_wlock`

## Requirements
- R1: After reset the bank is locked (`unlocked` low), no bit of `bank_wstrb` is high, and `bus_rdata` reads zero.
- R2: A write to offset 0 whose bits [31:8] equal 24'h00A5A5 and whose bit 0 is 1 sets `unlocked`. The new value is visible right after the clock edge that captures the write.
- R3: A write to offset 0 whose bits [31:8] equal 24'h00A5A5 and whose bit 0 is 0 clears `unlocked`. It is visible right after the capturing edge.
- R4: A write to offset 0 whose bits [31:8] differ from 24'h00A5A5 leaves the lock state unchanged. Bits [7:1] of an offset-0 word have no effect.
- R5: While unlocked, a write to offset k (1 <= k < NREGS) raises `bank_wstrb[k]` for exactly the one cycle after the capturing edge. During that cycle `bank_wdata` holds the written word. At most one strobe bit is ever high.
- R6: While locked, a write to any offset other than 0 raises no strobe bit.
- R7: A write to an offset at or above NREGS raises no strobe bit. A read of such an offset returns zero.
- R8: A read of offset 0 returns the lock state in bit 0 and zeros in bits [31:1]. The value appears one cycle after the address is presented.
- R9: A read of offset k (1 <= k < NREGS) returns slice k of `bank_rdata` (bits [32k+31:32k]), one cycle after the address, whether locked or not.
- R10: `bank_wstrb[0]` never rises. Offset-0 writes are never forwarded to the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable, one write per cycle while high |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| bank_rdata | input | NREGS*32 (384) | Current contents of the protected registers, slice k for offset k |
| bank_wstrb | output | NREGS (12) | Per-register write strobe, bit k for offset k |
| bank_wdata | output | 32 | Registered write data accompanying a strobe |
| unlocked | output | 1 | Current write-access state, 1 when unlocked |

## Verification
Every result is due one clock edge after its stimulus. The lock state, the strobe and its data, and the read data all come from a single register stage fed by the bus inputs of the previous cycle. The bench therefore drives each stimulus on a falling edge and samples the outputs on the next falling edge, half a period after the capturing rising edge. For the lock readback, the read data reflects the lock state as it stood before the capturing edge. Reads of offset 0 are therefore issued only in cycles with no write to offset 0.

// File: rtl/wlock_pkg.sv
package wlock_pkg;
  localparam int WORD_W = 32;
  localparam logic [23:0] ACCESS_KEY = 24'h00A5A5;

  // Upper 24 bits of a control word must carry the key
  function automatic logic key_ok(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:8] == ACCESS_KEY;
  endfunction

  // Readback word of the control register
  function automatic logic [WORD_W-1:0] ctl_word(input logic open);
    return {{(WORD_W-1){1'b0}}, open};
  endfunction
endpackage

// File: rtl/wlock_ctrl.sv
module wlock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic key_write,
  input  logic key_bit,
  output logic unlocked_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         unlocked_q <= 1'b0;
    else if (key_write) unlocked_q <= key_bit;
  end

  // R2/R3/R4: the lock state only moves on a key-qualified control write
  assert_lock_moves_on_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked_q != $past(unlocked_q)) |-> $past(key_write));
  // R2: a key write with bit 0 set opens the bank
  assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_write && key_bit) |=> unlocked_q);
  // R3: a key write with bit 0 clear closes the bank
  assert_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_write && !key_bit) |=> !unlocked_q);
endmodule

// File: rtl/wlock_decode.sv
module wlock_decode #(
  parameter int NREGS  = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              unlocked,
  output logic [NREGS-1:0]  wstrb_q,
  output logic [31:0]       wdata_q
);
  logic [NREGS-1:0] hit;

  // Offset 0 is the control register and never gets a bank strobe
  assign hit[0] = 1'b0;
  for (genvar k = 1; k < NREGS; k++) begin : g_hit
    assign hit[k] = we && unlocked && (addr == ADDR_W'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wstrb_q <= '0;
      wdata_q <= '0;
    end else begin
      wstrb_q <= hit;
      if (we) wdata_q <= wdata;
    end
  end

  // R6: nothing reaches the bank while locked
  assert_locked_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !unlocked) |=> (wstrb_q == '0));
  // R5: a strobe is never wider than one register
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wstrb_q));
  // R5: a strobe lasts one cycle unless a new write follows
  assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((wstrb_q != '0) && !we) |=> (wstrb_q == '0));
  // R10: control writes are not forwarded
  assert_no_ctl_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == '0) |=> (wstrb_q == '0));
endmodule

// File: rtl/wlock_rdmux.sv
module wlock_rdmux
  import wlock_pkg::*;
#(
  parameter int NREGS  = 12,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  unlocked,
  input  logic [NREGS*32-1:0]   bank_in,
  output logic [31:0]           rdata_q
);
  logic [31:0] slot [NREGS];
  logic [31:0] rd_next;

  for (genvar k = 0; k < NREGS; k++) begin : g_slot
    if (k == 0) begin : g_ctl
      assign slot[k] = ctl_word(unlocked);
    end else begin : g_bank
      assign slot[k] = bank_in[k*32 +: 32];
    end
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NREGS; k++)
      if (addr == ADDR_W'(k)) rd_next = slot[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_next;
  end

  // R8: control readback carries only the lock bit
  assert_ctl_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |=> (rdata_q == {31'b0, $past(unlocked)}));
  // R7: unmapped offsets read as zero
  assert_unmapped_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= ADDR_W'(NREGS)) |=> (rdata_q == '0));
endmodule

// File: rtl/regbank_wlock.sv
module regbank_wlock
  import wlock_pkg::*;
#(
  parameter int NREGS  = 12,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_we,
  output logic [31:0]         bus_rdata,
  input  logic [NREGS*32-1:0] bank_rdata,
  output logic [NREGS-1:0]    bank_wstrb,
  output logic [31:0]         bank_wdata,
  output logic                unlocked
);
  localparam int SPAN = 1 << ADDR_W;

  initial begin
    if (NREGS < 2 || NREGS > SPAN)
      $error("regbank_wlock: NREGS must lie in 2..2**ADDR_W");
  end

  // Named events for the lock controller
  logic ctl_sel;
  logic key_write;

  assign ctl_sel   = bus_we && (bus_addr == '0);
  assign key_write = ctl_sel && key_ok(bus_wdata);

  wlock_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_write (key_write),
    .key_bit   (bus_wdata[0]),
    .unlocked_q(unlocked)
  );

  wlock_decode #(.NREGS(NREGS), .ADDR_W(ADDR_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .unlocked(unlocked),
    .wstrb_q (bank_wstrb),
    .wdata_q (bank_wdata)
  );

  wlock_rdmux #(.NREGS(NREGS), .ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .unlocked(unlocked),
    .bank_in (bank_rdata),
    .rdata_q (bus_rdata)
  );

  // R4: a wrong key at offset 0 leaves the lock as it was
  assert_bad_key_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_sel && !key_ok(bus_wdata)) |=> $stable(unlocked));
  // R10: the control slot strobe never rises
  assert_ctl_strobe_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wstrb[0]);
endmodule

// File: tb/regbank_wlock_test.sv
module regbank_wlock_test;
  localparam int NREGS  = 12;
  localparam int ADDR_W = 4;
  localparam int NVEC   = 12;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [ADDR_W-1:0]   bus_addr = '0;
  logic [31:0]         bus_wdata = '0;
  logic                bus_we = 1'b0;
  logic [31:0]         bus_rdata;
  logic [NREGS*32-1:0] bank_rdata;
  logic [NREGS-1:0]    bank_wstrb;
  logic [31:0]         bank_wdata;
  logic                unlocked;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  for (genvar k = 0; k < NREGS; k++) begin : g_bank
    assign bank_rdata[k*32 +: 32] = 32'hC0DE_0000 | k;
  end

  regbank_wlock #(.NREGS(NREGS), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .bank_rdata(bank_rdata),
    .bank_wstrb(bank_wstrb), .bank_wdata(bank_wdata), .unlocked(unlocked)
  );

  // {we, addr, data, expected unlocked, expected strobes}
  localparam logic [49:0] VEC [NVEC] = '{
    {1'b1, 4'd3,  32'h1234_0003, 1'b0, 12'h000},  // R6 locked drop
    {1'b1, 4'd0,  32'h00A5_A501, 1'b1, 12'h000},  // R2 unlock
    {1'b1, 4'd3,  32'h1234_0003, 1'b1, 12'h008},  // R5 strobe 3
    {1'b1, 4'd0,  32'h0012_A500, 1'b1, 12'h000},  // R4 bad key kept
    {1'b1, 4'd11, 32'hBEEF_000B, 1'b1, 12'h800},  // R5 top register
    {1'b1, 4'd12, 32'hDEAD_000C, 1'b1, 12'h000},  // R7 unmapped
    {1'b1, 4'd0,  32'h00A5_A500, 1'b0, 12'h000},  // R3 relock
    {1'b1, 4'd5,  32'h5555_0005, 1'b0, 12'h000},  // R6 locked drop
    {1'b1, 4'd0,  32'h01A5_A501, 1'b0, 12'h000},  // R4 bit 24 set
    {1'b1, 4'd0,  32'h00A5_A5FF, 1'b1, 12'h000},  // R4 bits 7:1 ignored
    {1'b0, 4'd0,  32'h00A5_A500, 1'b1, 12'h000},  // R2 no write, no change
    {1'b1, 4'd0,  32'h00A5_A5FE, 1'b0, 12'h000}   // R3 relock, R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 unlocked", {31'b0, unlocked}, 32'h0);
    chk("R1 strobes", {20'b0, bank_wstrb}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      bus_we    = VEC[i][49];
      bus_addr  = VEC[i][48:45];
      bus_wdata = VEC[i][44:13];
      @(negedge clk);
      chk($sformatf("R2/R3/R4 lock vec%0d", i), {31'b0, unlocked}, {31'b0, VEC[i][12]});
      chk($sformatf("R5/R6/R7/R10 strobe vec%0d", i), {20'b0, bank_wstrb}, {20'b0, VEC[i][11:0]});
      if (VEC[i][11:0] != 12'h0)
        chk($sformatf("R5 data vec%0d", i), bank_wdata, VEC[i][44:13]);
    end
    bus_we = 1'b0;

    // R8 readback while locked and unlocked
    rd(4'd0, 32'h0, "R8 locked readback");
    @(negedge clk); bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h00A5_A501;
    @(negedge clk); bus_we = 1'b0;
    rd(4'd0, 32'h1, "R8 unlocked readback");

    // R5 strobe lasts exactly one cycle
    bus_we = 1'b1; bus_addr = 4'd7; bus_wdata = 32'h7777_0007;
    @(negedge clk); bus_we = 1'b0;
    chk("R5 strobe 7", {20'b0, bank_wstrb}, 32'h080);
    @(negedge clk);
    chk("R5 strobe drops", {20'b0, bank_wstrb}, 32'h0);

    // R9 reads regardless of lock, R7 unmapped read
    rd(4'd4, 32'hC0DE_0004, "R9 read unlocked");
    rd(4'd13, 32'h0, "R7 unmapped read");
    @(negedge clk); bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h00A5_A500;
    @(negedge clk); bus_we = 1'b0;
    rd(4'd11, 32'hC0DE_000B, "R9 read locked");
    rd(4'd0, 32'h0, "R8 relocked readback");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule